// File: doc/BRIEF.md
# Addressing Status and Accumulator Saturation Unit

This unit keeps the small set of CPU status fields that steer operand addressing and accumulator overflow handling. It holds a 3-bit auxiliary register pointer, which picks one of eight auxiliary registers for indirect addressing, and a 3-bit backup of that pointer. It also holds an overflow-mode bit, a test/control flag and a 9-bit data page pointer. The instruction decoder drives plain one-cycle strobes into the unit. Every field updates on the clock edge that samples its strobe.

Two outputs are combinational. The first is the 16-bit direct data address, with the page pointer in the upper 9 bits and the 7-bit instruction offset in the lower 7 bits. Each page therefore holds 128 words. The second is the accumulator write value. The ALU supplies a 41-bit signed result, and the unit clips it to the 32-bit signed range when overflow mode is on. When overflow mode is off, the unit passes the low 40 bits through unchanged.

There is no handshake on either path. The saturation and address paths have no storage and cannot stall, so they carry no valid/ready pair. All other pins are control or status pins. In silicon the stored fields have no defined reset value. The parameter `ZERO_RESET` makes them reset to zero instead.

Top module: `stat_addr_unit`

## Requirements
- R1: With `ZERO_RESET`=1, every stored field (pointer, backup, overflow mode, test flag, page) reads 0 after reset. With `ZERO_RESET`=0 they are left unknown.
- R2: A pointer load (`ptr_ld`) alone writes `ptr_val` into the pointer and copies the pointer's previous value into the backup, both on the same edge.
- R3: A status-0 restore (`st0_ld`) writes the pointer, the overflow-mode bit and the page from `st0_ptr`, `st0_ovm` and `st0_page`. It leaves the backup unchanged.
- R4: A status-1 restore (`st1_ld`) writes `st1_buf` into both the backup and the pointer, and writes `st1_tc` into the test flag.
- R5: With overflow mode 1, a result above 2^31-1 yields 0x00_7FFF_FFFF on `acc_out`, and a result below -2^31 yields 0xFF_8000_0000. A result inside the range passes through unchanged as its low 40 bits.
- R6: With overflow mode 0, `acc_out` always equals bits 39:0 of `acc_res`.
- R7: `daddr` equals {page, `dofs`}: the page occupies bits 15:7 and the offset occupies bits 6:0. It follows the current inputs in the same cycle.
- R8: A page load (`page_ld`) writes `page_val` into the page, unless a status-0 restore occurs on the same edge. In that case the restore value wins.
- R9: `ovm_set` sets the overflow-mode bit and `ovm_clr` clears it. The priority is status-0 restore, then set, then clear.
- R10: `tc_ld` writes `tc_val` into the test flag, unless a status-1 restore occurs on the same edge. In that case `st1_tc` wins.
- R11: For the pointer, status-1 restore beats status-0 restore, which beats pointer load. The backup is loaded only by status-1 restore, or by a pointer load that wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_ld | input | 1 | Ordinary pointer load strobe |
| ptr_val | input | 3 | New pointer value |
| st0_ld | input | 1 | Status-0 restore strobe |
| st0_ptr | input | 3 | Restored pointer |
| st0_ovm | input | 1 | Restored overflow mode |
| st0_page | input | 9 | Restored page |
| st1_ld | input | 1 | Status-1 restore strobe |
| st1_buf | input | 3 | Restored backup, also copied to the pointer |
| st1_tc | input | 1 | Restored test flag |
| page_ld | input | 1 | Page load strobe |
| page_val | input | 9 | New page value |
| ovm_set | input | 1 | Set overflow mode |
| ovm_clr | input | 1 | Clear overflow mode |
| tc_ld | input | 1 | Test flag update strobe |
| tc_val | input | 1 | New test flag value |
| dofs | input | 7 | Instruction offset for direct addressing |
| acc_res | input | 41 | Signed ALU result |
| arp | output | 3 | Auxiliary register pointer |
| arb | output | 3 | Pointer backup |
| ovm | output | 1 | Overflow mode |
| tc | output | 1 | Test/control flag |
| page | output | 9 | Data page pointer |
| daddr | output | 16 | Direct data address |
| acc_out | output | 40 | Accumulator write value |

## Verification
The clocked assertions assume that reset has been applied and that the stored fields hold known values. For this reason the bench builds the unit with `ZERO_RESET`=1. The strobes may be asserted in any combination, and the assertions on the pointer and page are conditioned on the winning strobe only. The random stimulus raises each strobe independently, so the bench covers conflicting strobes as well as single ones. It biases `acc_res` towards the edges of the 32-bit range and towards large magnitudes, so that both saturation directions and pass-through all occur.

// File: rtl/stat_unit_pkg.sv
package stat_unit_pkg;
  typedef enum logic [1:0] {
    PSRC_HOLD = 2'd0,
    PSRC_LOAD = 2'd1,
    PSRC_ST0  = 2'd2,
    PSRC_ST1  = 2'd3
  } ptr_src_e;

  typedef enum logic [1:0] {
    OVM_HOLD = 2'd0,
    OVM_ST0  = 2'd1,
    OVM_SET  = 2'd2,
    OVM_CLR  = 2'd3
  } ovm_src_e;
endpackage

// File: rtl/arp_ctrl.sv
module arp_ctrl
  import stat_unit_pkg::*;
#(
  parameter int PTR_W      = 3,
  parameter int ZERO_RESET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_ld,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             st0_ld,
  input  logic [PTR_W-1:0] st0_ptr,
  input  logic             st1_ld,
  input  logic [PTR_W-1:0] st1_buf,
  output logic [PTR_W-1:0] arp,
  output logic [PTR_W-1:0] arb
);
  localparam logic [PTR_W-1:0] RST_V = (ZERO_RESET != 0) ? '0 : 'x;

  ptr_src_e src;

  always_comb begin
    if (st1_ld)      src = PSRC_ST1;
    else if (st0_ld) src = PSRC_ST0;
    else if (ptr_ld) src = PSRC_LOAD;
    else             src = PSRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arp <= RST_V;
      arb <= RST_V;
    end else begin
      unique case (src)
        PSRC_ST1: begin
          arp <= st1_buf;
          arb <= st1_buf;
        end
        PSRC_ST0:  arp <= st0_ptr;
        PSRC_LOAD: begin
          arp <= ptr_val;
          arb <= arp;
        end
        default: ;
      endcase
    end
  end

  // R2: the old pointer is moved into the backup on a winning ordinary load
  a_r2_backup_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_ld && !st0_ld && !st1_ld) |=> (arb == $past(arp) && arp == $past(ptr_val)));
  // R3: status-0 restore leaves the backup alone
  a_r3_restore0_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_ld && !st1_ld) |=> (arb == $past(arb) && arp == $past(st0_ptr)));
  // R4: status-1 restore makes pointer and backup equal
  a_r4_restore1_pair: assert property (@(posedge clk) disable iff (!rst_n)
    st1_ld |=> (arp == arb));
  // R11: without strobes nothing moves
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_ld && !st0_ld && !st1_ld) |=> ($stable(arp) && $stable(arb)));
endmodule

// File: rtl/page_addr.sv
module page_addr #(
  parameter int PAGE_W     = 9,
  parameter int OFS_W      = 7,
  parameter int ZERO_RESET = 0,
  localparam int ADDR_W    = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_ld,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              st0_ld,
  input  logic [PAGE_W-1:0] st0_page,
  input  logic [OFS_W-1:0]  dofs,
  output logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] daddr
);
  localparam logic [PAGE_W-1:0] RST_V = (ZERO_RESET != 0) ? '0 : 'x;

  always_ff @(posedge clk) begin
    if (!rst_n)       page <= RST_V;
    else if (st0_ld)  page <= st0_page;
    else if (page_ld) page <= page_val;
  end

  assign daddr = {page, dofs};

  // R8: a page load without a competing restore lands
  a_r8_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    (page_ld && !st0_ld) |=> (page == $past(page_val)));
  // R3: status-0 restore writes the page
  a_r3_page_restore: assert property (@(posedge clk) disable iff (!rst_n)
    st0_ld |=> (page == $past(st0_page)));
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import stat_unit_pkg::*;
#(
  parameter int ZERO_RESET = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic st0_ld,
  input  logic st0_ovm,
  input  logic ovm_set,
  input  logic ovm_clr,
  input  logic st1_ld,
  input  logic st1_tc,
  input  logic tc_ld,
  input  logic tc_val,
  output logic ovm,
  output logic tc
);
  localparam logic RST_V = (ZERO_RESET != 0) ? 1'b0 : 1'bx;

  ovm_src_e osrc;

  always_comb begin
    if (st0_ld)       osrc = OVM_ST0;
    else if (ovm_set) osrc = OVM_SET;
    else if (ovm_clr) osrc = OVM_CLR;
    else              osrc = OVM_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovm <= RST_V;
      tc  <= RST_V;
    end else begin
      unique case (osrc)
        OVM_ST0: ovm <= st0_ovm;
        OVM_SET: ovm <= 1'b1;
        OVM_CLR: ovm <= 1'b0;
        default: ;
      endcase
      if (st1_ld)     tc <= st1_tc;
      else if (tc_ld) tc <= tc_val;
    end
  end

  // R9: set strobe wins over clear when no restore competes
  a_r9_ovm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ovm_set && !st0_ld) |=> ovm);
  a_r9_ovm_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (ovm_clr && !ovm_set && !st0_ld) |=> !ovm);
  // R10: restore beats the ordinary flag update
  a_r10_tc_restore: assert property (@(posedge clk) disable iff (!rst_n)
    st1_ld |=> (tc == $past(st1_tc)));
endmodule

// File: rtl/acc_sat.sv
module acc_sat #(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic [ACC_W:0]   res,
  input  logic             ovm,
  output logic [ACC_W-1:0] out
);
  localparam int HI_W = ACC_W - SAT_W + 2;
  localparam logic [ACC_W-1:0] POS_MAX = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MIN = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic [HI_W-1:0] upper;
  logic            pos_ovf, neg_ovf;

  assign upper   = res[ACC_W:SAT_W-1];
  assign pos_ovf = !res[ACC_W] && (|upper);
  assign neg_ovf =  res[ACC_W] && !(&upper);

  always_comb begin
    if (ovm && pos_ovf)      out = POS_MAX;
    else if (ovm && neg_ovf) out = NEG_MIN;
    else                     out = res[ACC_W-1:0];
  end

  // R5: in overflow mode the written value always fits the narrow signed range
  always_comb begin
    if (ovm === 1'b1)
      a_r5_sat_range: assert (&out[ACC_W-1:SAT_W-1] || !(|out[ACC_W-1:SAT_W-1]));
  end
endmodule

// File: rtl/stat_addr_unit.sv
module stat_addr_unit #(
  parameter int PTR_W      = 3,
  parameter int PAGE_W     = 9,
  parameter int OFS_W      = 7,
  parameter int ACC_W      = 40,
  parameter int SAT_W      = 32,
  parameter int ZERO_RESET = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ptr_ld,
  input  logic [PTR_W-1:0]        ptr_val,
  input  logic                    st0_ld,
  input  logic [PTR_W-1:0]        st0_ptr,
  input  logic                    st0_ovm,
  input  logic [PAGE_W-1:0]       st0_page,
  input  logic                    st1_ld,
  input  logic [PTR_W-1:0]        st1_buf,
  input  logic                    st1_tc,
  input  logic                    page_ld,
  input  logic [PAGE_W-1:0]       page_val,
  input  logic                    ovm_set,
  input  logic                    ovm_clr,
  input  logic                    tc_ld,
  input  logic                    tc_val,
  input  logic [OFS_W-1:0]        dofs,
  input  logic [ACC_W:0]          acc_res,
  output logic [PTR_W-1:0]        arp,
  output logic [PTR_W-1:0]        arb,
  output logic                    ovm,
  output logic                    tc,
  output logic [PAGE_W-1:0]       page,
  output logic [PAGE_W+OFS_W-1:0] daddr,
  output logic [ACC_W-1:0]        acc_out
);
  arp_ctrl #(.PTR_W(PTR_W), .ZERO_RESET(ZERO_RESET)) u_arp (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .st0_ld(st0_ld), .st0_ptr(st0_ptr), .st1_ld(st1_ld), .st1_buf(st1_buf),
    .arp(arp), .arb(arb)
  );

  page_addr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .ZERO_RESET(ZERO_RESET)) u_page (
    .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_val(page_val),
    .st0_ld(st0_ld), .st0_page(st0_page), .dofs(dofs),
    .page(page), .daddr(daddr)
  );

  flag_ctrl #(.ZERO_RESET(ZERO_RESET)) u_flag (
    .clk(clk), .rst_n(rst_n), .st0_ld(st0_ld), .st0_ovm(st0_ovm),
    .ovm_set(ovm_set), .ovm_clr(ovm_clr), .st1_ld(st1_ld), .st1_tc(st1_tc),
    .tc_ld(tc_ld), .tc_val(tc_val), .ovm(ovm), .tc(tc)
  );

  acc_sat #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_sat (
    .res(acc_res), .ovm(ovm), .out(acc_out)
  );
endmodule

// File: tb/sim_stat_addr_unit.sv
`timescale 1ns/1ps
module sim_stat_addr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_ld = 0, st0_ld = 0, st1_ld = 0, page_ld = 0;
  logic ovm_set = 0, ovm_clr = 0, tc_ld = 0, tc_val = 0, st0_ovm = 0, st1_tc = 0;
  logic [2:0] ptr_val = 0, st0_ptr = 0, st1_buf = 0;
  logic [8:0] st0_page = 0, page_val = 0;
  logic [6:0] dofs = 0;
  logic [40:0] acc_res = 0;
  logic [2:0] arp, arb;
  logic ovm, tc;
  logic [8:0] page;
  logic [15:0] daddr;
  logic [39:0] acc_out;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [2:0] m_arp, m_arb;
  logic m_ovm, m_tc;
  logic [8:0] m_page;

  always #4 clk = ~clk;

  stat_addr_unit #(.ZERO_RESET(1)) u0 (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .st0_ld(st0_ld), .st0_ptr(st0_ptr), .st0_ovm(st0_ovm), .st0_page(st0_page),
    .st1_ld(st1_ld), .st1_buf(st1_buf), .st1_tc(st1_tc),
    .page_ld(page_ld), .page_val(page_val), .ovm_set(ovm_set), .ovm_clr(ovm_clr),
    .tc_ld(tc_ld), .tc_val(tc_val), .dofs(dofs), .acc_res(acc_res),
    .arp(arp), .arb(arb), .ovm(ovm), .tc(tc), .page(page),
    .daddr(daddr), .acc_out(acc_out)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint exp_acc(logic [40:0] r, logic mode);
    longint v;
    v = longint'($signed(r));
    if (mode && v > 64'sd2147483647)  return 64'h00_7FFF_FFFF;
    if (mode && v < -64'sd2147483648) return 64'hFF_8000_0000;
    return longint'(r[39:0]);
  endfunction

  task automatic compare_all();
    chk("R2/R3/R4/R11 arp", longint'(arp), longint'(m_arp));
    chk("R2/R3/R4/R11 arb", longint'(arb), longint'(m_arb));
    chk("R3/R9 ovm", longint'(ovm), longint'(m_ovm));
    chk("R4/R10 tc", longint'(tc), longint'(m_tc));
    chk("R3/R8 page", longint'(page), longint'(m_page));
    chk("R7 daddr", longint'(daddr), longint'({m_page, dofs}));
    chk(m_ovm ? "R5 acc_out" : "R6 acc_out", longint'(acc_out), exp_acc(acc_res, m_ovm));
  endtask

  task automatic model_step();
    logic [2:0] old_arp;
    old_arp = m_arp;
    if (st1_ld) begin m_arp = st1_buf; m_arb = st1_buf; end
    else if (st0_ld) m_arp = st0_ptr;
    else if (ptr_ld) begin m_arp = ptr_val; m_arb = old_arp; end
    if (st0_ld) m_page = st0_page; else if (page_ld) m_page = page_val;
    if (st0_ld) m_ovm = st0_ovm; else if (ovm_set) m_ovm = 1'b1; else if (ovm_clr) m_ovm = 1'b0;
    if (st1_ld) m_tc = st1_tc; else if (tc_ld) m_tc = tc_val;
  endtask

  task automatic clear_strobes();
    ptr_ld = 0; st0_ld = 0; st1_ld = 0; page_ld = 0;
    ovm_set = 0; ovm_clr = 0; tc_ld = 0;
  endtask

  task automatic cycle();
    #1 compare_all();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
  endtask

  function automatic logic [40:0] pick_acc();
    logic [40:0] r;
    r = {$urandom(), $urandom()};
    case ($urandom_range(0, 4))
      0: r = {{10{r[31]}}, r[30:0]};
      1: r = 41'h000_7FFF_FFFF + 41'(r[1:0]);
      2: r = 41'h1FF_8000_0000 - 41'(r[1:0]);
      3: r = {1'b0, r[39:0]};
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_arp = 0; m_arb = 0; m_ovm = 0; m_tc = 0; m_page = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: zero reset state
    chk("R1 arp", longint'(arp), 0);
    chk("R1 arb", longint'(arb), 0);
    chk("R1 ovm", longint'(ovm), 0);
    chk("R1 tc", longint'(tc), 0);
    chk("R1 page", longint'(page), 0);

    // R2: ordinary load pushes old pointer into backup
    ptr_ld = 1; ptr_val = 3'd5; cycle();
    ptr_val = 3'd2; cycle();
    clear_strobes(); cycle();
    chk("R2 arb holds old pointer", longint'(arb), 5);

    // R3: restore 0 keeps backup
    st0_ld = 1; st0_ptr = 3'd7; st0_ovm = 1; st0_page = 9'h1A3; cycle();
    clear_strobes(); cycle();
    chk("R3 arb unchanged", longint'(arb), 5);

    // R5: saturation with mode on (set by restore above)
    acc_res = 41'h000_8000_0000; #1;
    chk("R5 positive clip", longint'(acc_out), 64'h00_7FFF_FFFF);
    acc_res = 41'h1FF_7FFF_FFFF; #1;
    chk("R5 negative clip", longint'(acc_out), 64'hFF_8000_0000);
    acc_res = 41'h1FF_8000_0000; #1;
    chk("R5 in range edge", longint'(acc_out), 64'hFF_8000_0000);
    @(negedge clk);

    // R9: clear, then R6 pass-through
    ovm_clr = 1; cycle(); clear_strobes();
    acc_res = 41'h000_8000_0000; cycle();

    // R4: restore 1 pairs pointer and backup
    st1_ld = 1; st1_buf = 3'd3; st1_tc = 1; ptr_ld = 1; ptr_val = 3'd6; cycle();
    clear_strobes(); cycle();

    // random mixed stimulus, R11 priority conflicts included
    for (int i = 0; i < 4000; i++) begin
      ptr_ld  = ($urandom_range(0, 3) == 0);
      st0_ld  = ($urandom_range(0, 7) == 0);
      st1_ld  = ($urandom_range(0, 7) == 0);
      page_ld = ($urandom_range(0, 3) == 0);
      ovm_set = ($urandom_range(0, 5) == 0);
      ovm_clr = ($urandom_range(0, 5) == 0);
      tc_ld   = ($urandom_range(0, 3) == 0);
      tc_val  = 1'($urandom());
      st0_ovm = 1'($urandom());
      st1_tc  = 1'($urandom());
      ptr_val = 3'($urandom()); st0_ptr = 3'($urandom()); st1_buf = 3'($urandom());
      st0_page = 9'($urandom()); page_val = 9'($urandom());
      dofs = 7'($urandom());
      acc_res = pick_acc();
      cycle();
    end
    clear_strobes(); cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule